// File: doc/BRIEF.md
# Byte/Word Flash Host Bus Front End

This block sits between the asynchronous host pins of a parallel NOR-style flash device and its clocked internal logic. Active-low chip select, output enable and write strobe, an active-low power-down input and a bus-width select are brought into the system clock domain through two-flop synchronizers. Address and data inputs are delayed by the same two stages so that they stay aligned with the controls. The block forms the internal array address. In 8-bit mode the top data pin is taken as an extra low-order address bit that picks the upper or lower half of the array word.

For reads, the block picks one of three sources: the array word, a status byte or an identifier code. It steers the result onto a 16-bit output bus with separate enables for the low and high byte lanes. The status source is frozen when a read access begins, so a new value only appears after a strobe has been toggled. For writes, the block captures address and data while the write is active. It emits one single-cycle pulse to the command decoder when the chip select or the write strobe ends the write.

Top module: `flash_bus_if`

## Requirements
- R1: While the synchronized power-down input is low, both lane enables stay 0 and no command pulse is produced, even if a write ends during power-down.
- R2: With chip select high, both lane enables are 0 whatever the output enable and write strobe levels.
- R3: With chip select low and output enable high, both lane enables are 0.
- R4: In 16-bit mode (`x16_sel`=1), a read with chip select and output enable low drives both lanes, `dq_out` equals `array_rdata` when `rd_src` is 0 (array) or 3 (reserved, treated as array), `arr_addr` equals `addr_in`, and `arr_lane_hi` is 0. The outputs respond on the second clock edge after the pins change.
- R5: In 8-bit mode (`x16_sel`=0), `arr_lane_hi` follows `dq_in[15]`, only the low lane is enabled, and `dq_out[7:0]` carries `array_rdata[15:8]` when that bit is 1 and `array_rdata[7:0]` when it is 0.
- R6: A write (chip select low, write strobe low, output enable high) yields exactly one `cmd_valid` pulse of one cycle, whichever of the two strobes rises first. The pulse carries the address, and carries the full data word in 16-bit mode. In 8-bit mode it carries `{8'h00, dq_in[7:0]}` with `cmd_lane_hi` = `dq_in[15]`.
- R7: With `rd_src`=1 (status), `dq_out[7:0]` shows `status_in` as sampled when the read became active, and the upper byte is 00h in 16-bit mode. Later changes of `status_in` appear only after chip select or output enable has gone high and low again.
- R8: With `rd_src`=2 (identifier), `addr_in[0]`=0 returns the manufacturer code 20h and `addr_in[0]`=1 returns the device code (parameter, default 96h). The upper byte is 00h in 16-bit mode. In 8-bit mode the high lane is disabled and `dq_in[15]` has no effect.
- R9: During and right after synchronous reset, both lane enables and `cmd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| rp_n | input | 1 | Power-down, active low |
| x16_sel | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| addr_in | input | 18 | Word address pins |
| dq_in | input | 16 | Data pins as seen by the input buffers |
| rd_src | input | 2 | Read source: 0 array, 1 status, 2 identifier, 3 array |
| array_rdata | input | 16 | Word read from the array |
| status_in | input | 8 | Live status byte |
| arr_addr | output | 18 | Synchronized word address to the array |
| arr_lane_hi | output | 1 | Upper-byte select in 8-bit mode |
| dq_out | output | 16 | Data driven toward the pins |
| dq_oe_lo | output | 1 | Output enable for bits 7:0 |
| dq_oe_hi | output | 1 | Output enable for bits 15:8 |
| cmd_valid | output | 1 | Single-cycle write pulse |
| cmd_addr | output | 18 | Captured write address |
| cmd_lane_hi | output | 1 | Captured upper-byte select |
| cmd_data | output | 16 | Captured write data |

## Verification
A stuck or stale read-activity flag would show up at the next access. Either a lane enable stays on after the strobes are released, or a status read keeps an old byte across a strobe toggle. Both are visible about three cycles after the pins move. A wrong write-activity flag shows as a missing, doubled or spurious `cmd_valid` within three cycles of the strobe release. A bad lane or width latch shows as the wrong byte on the low lane or as the high lane enabled in 8-bit mode.

// File: rtl/flash_bus_pkg.sv
`timescale 1ns/1ps
package flash_bus_pkg;

    localparam int ADDR_W = 18;
    localparam int DATA_W = 16;
    localparam int BYTE_W = DATA_W / 2;
    localparam int STAT_W = 8;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_STATUS = 2'd1,
        SRC_IDENT  = 2'd2,
        SRC_RSVD   = 2'd3
    } rd_src_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic rp_n;
        logic x16;
    } pin_ctl_t;

    localparam int CTL_W = $bits(pin_ctl_t);
    localparam pin_ctl_t CTL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                      rp_n: 1'b1, x16: 1'b1};

    function automatic logic is_read(input pin_ctl_t c);
        return c.rp_n && !c.ce_n && !c.oe_n;
    endfunction

    function automatic logic is_write(input pin_ctl_t c);
        return c.rp_n && !c.ce_n && !c.we_n && c.oe_n;
    endfunction

    function automatic logic [BYTE_W-1:0] ident_code(
        input logic sel_dev, input logic [BYTE_W-1:0] mfr,
        input logic [BYTE_W-1:0] dev);
        return sel_dev ? dev : mfr;
    endfunction

endpackage

// File: rtl/fbi_sync.sv
`timescale 1ns/1ps
module fbi_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= RST_VAL;
        else     stage[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[i] <= RST_VAL;
            else     stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/fbi_wr_capture.sv
`timescale 1ns/1ps
module fbi_wr_capture
    import flash_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_ctl_t          ctl,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] dq_s,
    output logic              cmd_valid,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_lane_hi,
    output logic [DATA_W-1:0] cmd_data
);
    logic wr_act, wr_prev;

    assign wr_act = is_write(ctl);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev     <= 1'b0;
            cmd_valid   <= 1'b0;
            cmd_addr    <= '0;
            cmd_lane_hi <= 1'b0;
            cmd_data    <= '0;
        end else begin
            wr_prev   <= wr_act;
            cmd_valid <= wr_prev && !wr_act && ctl.rp_n;
            if (wr_act) begin
                cmd_addr <= addr_s;
                if (ctl.x16) begin
                    cmd_lane_hi <= 1'b0;
                    cmd_data    <= dq_s;
                end else begin
                    cmd_lane_hi <= dq_s[DATA_W-1];
                    cmd_data    <= {{BYTE_W{1'b0}}, dq_s[BYTE_W-1:0]};
                end
            end
        end
    end

    assert_one_cycle_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);
    assert_pulse_needs_power_R1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(ctl.rp_n));
    assert_pulse_after_write_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(wr_prev));
endmodule

// File: rtl/fbi_read_path.sv
`timescale 1ns/1ps
module fbi_read_path
    import flash_bus_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MFR_CODE = 8'h20,
    parameter logic [BYTE_W-1:0] DEV_CODE = 8'h96
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_ctl_t          ctl,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic              lane_hi,
    input  rd_src_e           src,
    input  logic [DATA_W-1:0] array_rdata,
    input  logic [STAT_W-1:0] status_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe_lo,
    output logic              dq_oe_hi
);
    logic              rd_en, rd_prev, rd_first;
    logic [STAT_W-1:0] stat_hold, stat_now;
    logic [BYTE_W-1:0] id_byte, arr_byte;

    assign rd_en    = is_read(ctl);
    assign rd_first = rd_en && !rd_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_prev   <= 1'b0;
            stat_hold <= '0;
        end else begin
            rd_prev <= rd_en;
            if (rd_first) stat_hold <= status_in;
        end
    end

    assign stat_now = rd_first ? status_in : stat_hold;
    assign id_byte  = ident_code(addr_s[0], MFR_CODE, DEV_CODE);
    assign arr_byte = lane_hi ? array_rdata[DATA_W-1:BYTE_W]
                              : array_rdata[BYTE_W-1:0];

    always_comb begin
        dq_out = '0;
        unique case (src)
            SRC_STATUS: dq_out[BYTE_W-1:0] = stat_now;
            SRC_IDENT:  dq_out[BYTE_W-1:0] = id_byte;
            default: begin
                if (ctl.x16) dq_out = array_rdata;
                else         dq_out[BYTE_W-1:0] = arr_byte;
            end
        endcase
    end

    assign dq_oe_lo = rd_en;
    assign dq_oe_hi = rd_en && ctl.x16;

    assert_hi_needs_lo_R5: assert property (@(posedge clk) disable iff (rst)
        dq_oe_hi |-> dq_oe_lo);
    assert_status_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_prev) |=> (!rd_en || !rd_prev || $stable(stat_hold)));
    assert_standby_float_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.ce_n |-> !dq_oe_lo && !dq_oe_hi);
endmodule

// File: rtl/flash_bus_if.sv
`timescale 1ns/1ps
module flash_bus_if
    import flash_bus_pkg::*;
#(
    parameter logic [7:0] MFR_CODE = 8'h20,
    parameter logic [7:0] DEV_CODE = 8'h96
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic        rp_n,
    input  logic        x16_sel,
    input  logic [17:0] addr_in,
    input  logic [15:0] dq_in,
    input  logic [1:0]  rd_src,
    input  logic [15:0] array_rdata,
    input  logic [7:0]  status_in,
    output logic [17:0] arr_addr,
    output logic        arr_lane_hi,
    output logic [15:0] dq_out,
    output logic        dq_oe_lo,
    output logic        dq_oe_hi,
    output logic        cmd_valid,
    output logic [17:0] cmd_addr,
    output logic        cmd_lane_hi,
    output logic [15:0] cmd_data
);
    localparam int BUS_W = ADDR_W + DATA_W;

    pin_ctl_t          ctl_raw, ctl_s;
    logic [CTL_W-1:0]  ctl_q;
    logic [BUS_W-1:0]  bus_q;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] dq_s;
    logic              lane_hi_s;

    assign ctl_raw = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n, rp_n: rp_n, x16: x16_sel};

    fbi_sync #(.W(CTL_W), .STAGES(2), .RST_VAL(CTL_IDLE)) u_ctl_sync (
        .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_q));

    fbi_sync #(.W(BUS_W), .STAGES(2), .RST_VAL('0)) u_bus_sync (
        .clk(clk), .rst(rst), .d({addr_in, dq_in}), .q(bus_q));

    assign ctl_s     = pin_ctl_t'(ctl_q);
    assign addr_s    = bus_q[BUS_W-1:DATA_W];
    assign dq_s      = bus_q[DATA_W-1:0];
    assign lane_hi_s = !ctl_s.x16 && dq_s[DATA_W-1];

    assign arr_addr    = addr_s;
    assign arr_lane_hi = lane_hi_s;

    fbi_read_path #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_read (
        .clk(clk), .rst(rst), .ctl(ctl_s), .addr_s(addr_s),
        .lane_hi(lane_hi_s), .src(rd_src_e'(rd_src)),
        .array_rdata(array_rdata), .status_in(status_in),
        .dq_out(dq_out), .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi));

    fbi_wr_capture u_write (
        .clk(clk), .rst(rst), .ctl(ctl_s), .addr_s(addr_s), .dq_s(dq_s),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_lane_hi(cmd_lane_hi), .cmd_data(cmd_data));

    assert_powerdown_float_R1: assert property (@(posedge clk) disable iff (rst)
        !ctl_s.rp_n |-> !dq_oe_lo && !dq_oe_hi);
    assert_byte_mode_hi_off_R5: assert property (@(posedge clk) disable iff (rst)
        !ctl_s.x16 |-> !dq_oe_hi);
    assert_no_drive_on_write_R3: assert property (@(posedge clk) disable iff (rst)
        ctl_s.oe_n |-> !dq_oe_lo);
    assert_reset_quiet_R9: assert property (@(posedge clk)
        $past(rst) |-> !cmd_valid && !dq_oe_lo);
endmodule

// File: tb/flash_bus_if_test.sv
`timescale 1ns/1ps
module flash_bus_if_test;
    logic clk = 1'b0, rst = 1'b1;
    logic ce_n = 1, oe_n = 1, we_n = 1, rp_n = 1, x16_sel = 1;
    logic [17:0] addr_in = '0;
    logic [15:0] dq_in = '0, array_rdata = '0;
    logic [1:0]  rd_src = 2'd0;
    logic [7:0]  status_in = '0;
    logic [17:0] arr_addr, cmd_addr;
    logic        arr_lane_hi, dq_oe_lo, dq_oe_hi, cmd_valid, cmd_lane_hi;
    logic [15:0] dq_out, cmd_data;

    int vectors = 0, miscompares = 0, pulses = 0;
    bit done = 0;

    typedef struct { logic [15:0] dq; logic lo; logic hi; string tag; } rd_item_t;
    typedef struct { logic [17:0] a; logic lane; logic [15:0] d; string tag; } wr_item_t;
    rd_item_t rd_q[$];
    wr_item_t wr_q[$];

    always #4 clk = ~clk;

    flash_bus_if uut (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rd(input logic [15:0] dq, input logic lo, input logic hi,
                             input string tag);
        rd_q.push_back('{dq, lo, hi, tag});
        wait (rd_q.size() == 0);
    endtask

    // read monitor: compares lane enables and enabled lanes only
    initial forever begin
        rd_item_t it;
        wait (rd_q.size() != 0);
        it = rd_q.pop_front();
        check(dq_oe_lo === it.lo && dq_oe_hi === it.hi, {it.tag, " enables"},
              {30'd0, dq_oe_hi, dq_oe_lo}, {30'd0, it.hi, it.lo});
        if (it.lo)
            check(dq_out[7:0] === it.dq[7:0], {it.tag, " low lane"},
                  {24'd0, dq_out[7:0]}, {24'd0, it.dq[7:0]});
        if (it.hi)
            check(dq_out[15:8] === it.dq[15:8], {it.tag, " high lane"},
                  {24'd0, dq_out[15:8]}, {24'd0, it.dq[15:8]});
    end

    // write monitor
    always @(negedge clk) if (!rst && cmd_valid) begin
        pulses++;
        if (wr_q.size() == 0) begin
            check(1'b0, "R6 unexpected cmd_valid", 32'd1, 32'd0);
        end else begin
            wr_item_t w;
            w = wr_q.pop_front();
            check(cmd_addr === w.a && cmd_lane_hi === w.lane && cmd_data === w.d,
                  {w.tag, " cmd fields"}, {cmd_lane_hi, cmd_addr[14:0], cmd_data},
                  {w.lane, w.a[14:0], w.d});
        end
    end

    task automatic write_we(input logic [17:0] a, input logic [15:0] d, input logic w16,
                            input string tag);
        wr_q.push_back('{a, w16 ? 1'b0 : d[15], w16 ? d : {8'h00, d[7:0]}, tag});
        addr_in = a; dq_in = d; x16_sel = w16; oe_n = 1;
        ce_n = 0; we_n = 0; settle(4);
        we_n = 1; settle(1); ce_n = 1; settle(6);
        check(wr_q.size() == 0, {tag, " pulse arrived"}, wr_q.size(), 0);
    endtask

    task automatic write_ce(input logic [17:0] a, input logic [15:0] d, input logic w16,
                            input string tag);
        wr_q.push_back('{a, w16 ? 1'b0 : d[15], w16 ? d : {8'h00, d[7:0]}, tag});
        addr_in = a; dq_in = d; x16_sel = w16; oe_n = 1;
        we_n = 0; settle(1); ce_n = 0; settle(4);
        ce_n = 1; settle(1); we_n = 1; settle(6);
        check(wr_q.size() == 0, {tag, " pulse arrived"}, wr_q.size(), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        vectors++; miscompares++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        int p0;
        settle(5);
        check(!dq_oe_lo && !dq_oe_hi && !cmd_valid, "R9 reset quiet",
              {dq_oe_lo, dq_oe_hi, cmd_valid}, 0);
        rst = 0; settle(2);
        check(!dq_oe_lo && !dq_oe_hi && !cmd_valid, "R9 after reset",
              {dq_oe_lo, dq_oe_hi, cmd_valid}, 0);

        // R4 word read, array source
        array_rdata = 16'hA5C3; addr_in = 18'h2ABCD; x16_sel = 1; rd_src = 2'd0;
        ce_n = 0; oe_n = 0; settle(3);
        expect_rd(16'hA5C3, 1, 1, "R4 word read");
        check(arr_addr === 18'h2ABCD && arr_lane_hi === 1'b0, "R4 address",
              {arr_lane_hi, arr_addr}, {1'b0, 18'h2ABCD});
        rd_src = 2'd3; settle(1);
        expect_rd(16'hA5C3, 1, 1, "R4 reserved source reads array");
        rd_src = 2'd0;

        // R5 byte reads
        x16_sel = 0; dq_in = 16'h0000; settle(3);
        expect_rd(16'h00C3, 1, 0, "R5 byte read lower");
        check(arr_lane_hi === 1'b0, "R5 lane bit low", arr_lane_hi, 0);
        dq_in = 16'h8000; settle(3);
        expect_rd(16'h00A5, 1, 0, "R5 byte read upper");
        check(arr_lane_hi === 1'b1, "R5 lane bit high", arr_lane_hi, 1);
        x16_sel = 1; dq_in = 0;

        // R3, R2, R1 float cases
        oe_n = 1; settle(3);
        expect_rd(16'h0, 0, 0, "R3 output disabled");
        ce_n = 1; oe_n = 0; we_n = 0; settle(3);
        expect_rd(16'h0, 0, 0, "R2 standby");
        we_n = 1; ce_n = 0; rp_n = 0; settle(3);
        expect_rd(16'h0, 0, 0, "R1 power-down");
        ce_n = 1; oe_n = 1; rp_n = 1; settle(3);

        // R7 status freeze
        rd_src = 2'd1; status_in = 8'h80; settle(1);
        ce_n = 0; oe_n = 0; settle(3);
        expect_rd(16'h0080, 1, 1, "R7 status sampled");
        status_in = 8'h08; settle(3);
        expect_rd(16'h0080, 1, 1, "R7 status held");
        oe_n = 1; settle(3); oe_n = 0; settle(3);
        expect_rd(16'h0008, 1, 1, "R7 status after toggle");

        // R8 identifier
        rd_src = 2'd2; addr_in = 18'h00000; settle(3);
        expect_rd(16'h0020, 1, 1, "R8 manufacturer code");
        addr_in = 18'h00001; settle(3);
        expect_rd(16'h0096, 1, 1, "R8 device code");
        x16_sel = 0; dq_in = 16'h8000; settle(3);
        expect_rd(16'h0096, 1, 0, "R8 byte mode ignores lane bit");
        ce_n = 1; oe_n = 1; x16_sel = 1; dq_in = 0; rd_src = 2'd0; settle(3);

        // R6 writes
        write_we(18'h00155, 16'h1234, 1'b1, "R6 word write via we");
        write_ce(18'h3F00A, 16'h80AB, 1'b0, "R6 byte write via ce");

        // R1 write ended during power-down
        p0 = pulses;
        addr_in = 18'h1; dq_in = 16'h40; oe_n = 1; ce_n = 0; we_n = 0; settle(4);
        rp_n = 0; settle(4); we_n = 1; ce_n = 1; settle(6);
        check(pulses == p0, "R1 no pulse in power-down", pulses - p0, 0);
        rp_n = 1; settle(3);
        check(pulses == 2, "R6 total pulse count", pulses, 2);

        finish_run();
    end
endmodule